// File: doc/BRIEF.md
# I2C Master Stop Sequencer and Control Register

This block sits beside the byte engine of an I2C master. It keeps a 16-bit control word that holds a start request, a stop request and a noise-filter enable. The same word carries two read-only activity flags, one for transmit and one for receive. The byte engine marks activity with strobes: the beginning of a transmit, the beginning of a receive, and the end of a transfer (the end counts only after the ACK bit). A wait-state input forces both activity flags low.

A stop request is not acted on when it is written. It stays pending until an end-of-transfer strobe arrives at a moment when the external transmit enable, the external receive enable and the start bit are all low. At that point a state machine drives the stop condition. Every step of that machine advances on the I2C clock enable.

The machine has five states:
- `SQ_IDLE` drives nothing.
- `SQ_PULL` pulls both SDA and SCL low.
- `SQ_RAISE` lets SCL go high while SDA stays low.
- `SQ_HOLD` keeps that level for `HOLD_TICKS` clock enables.
- `SQ_RELEASE` lets SDA go high while SCL stays high.

It has these transitions:
- `launch` takes `SQ_IDLE` to `SQ_PULL`.
- `tick` takes `SQ_PULL` to `SQ_RAISE`.
- `tick` takes `SQ_RAISE` to `SQ_HOLD`.
- `hold_done` takes `SQ_HOLD` to `SQ_RELEASE`.
- `finish` takes `SQ_RELEASE` back to `SQ_IDLE`.

On `finish` the stop bit clears itself and the bus-free flag is set. The filter enable is passed out to a noise filter that lives outside this block.

Top module: `i2c_stop_ctl`

## Requirements
- R1: After reset the control word reads 0x0000, `bus_free` is 1, and `sda_drive_low`, `scl_drive_low`, `filt_en` and `start_req` are all 0.
- R2: Bits 15..10, 7..5 and 3..2 of the control word always read 0. Writing 0xFFFF from idle reads back as 0x0013.
- R3: Bit 4 of the control word is the filter enable, and `filt_en` follows it from the cycle after the write.
- R4: Bit 8 is the transmit-busy flag. It is set by `tx_begin` and cleared by `xfer_done` or `wait_state`. When `wait_state` is high, clearing wins over setting. Register writes do not change it.
- R5: Bit 9 is the receive-busy flag. It is set by `rx_begin` and cleared by `xfer_done` or `wait_state`, with the same priority as bit 8. Register writes do not change it.
- R6: Bit 1 is the stop request. It launches the stop sequence only on an `xfer_done` strobe taken in `SQ_IDLE` while `tx_en`, `rx_en` and bit 0 are all 0. In any other case the bit stays 1 and SDA and SCL are not driven.
- R7: The stop sequence puts out these levels, as (SDA pulled low, SCL pulled low): (1,1), then (1,0), then (0,0). Every step waits for `scl_tick`. From the release of SCL to the release of SDA takes `HOLD_TICKS`+1 clock enables. SDA is never released while SCL is pulled low.
- R8: When the sequence ends, bit 1 reads 0 and `bus_free` rises in the same cycle. `bus_free` falls on the cycle after `tx_begin` or `rx_begin`.
- R9: While the sequence is in `SQ_PULL`, `SQ_RAISE` or `SQ_HOLD`, a write of 0 to bit 1 has no effect.
- R10: Bit 0 is the start request and drives `start_req`. A `start_issued` strobe clears it, and the strobe wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| scl_tick | input | 1 | One-cycle I2C clock enable |
| tx_begin | input | 1 | Byte engine has started a transmit |
| rx_begin | input | 1 | Byte engine has started a receive |
| xfer_done | input | 1 | Transfer finished, ACK bit included |
| wait_state | input | 1 | Engine is in its wait state |
| tx_en | input | 1 | Transmit enable from the data register |
| rx_en | input | 1 | Receive enable from the data register |
| start_issued | input | 1 | Start condition has been put on the bus |
| start_req | output | 1 | Pending start request |
| filt_en | output | 1 | Noise-filter enable |
| sda_drive_low | output | 1 | Pull SDA low during the stop sequence |
| scl_drive_low | output | 1 | Pull SCL low during the stop sequence |
| bus_free | output | 1 | Bus has been released by a stop |

## Verification
- **Register-driven outputs.** Every control bit, busy flag and `bus_free` is a register, so each is due one clock after the strobe or write that changes it. The bench applies each stimulus after a falling edge and holds it for one cycle. It reads the result at the next falling edge, which is exactly one rising edge later.
- **Stop-sequence outputs.** These levels depend on where `scl_tick` falls, so they are not checked at fixed cycle offsets. A driver task queues the expected levels in order before it triggers a stop. A monitor compares each observed change against the head of that queue.
- **Hold time.** The monitor also timestamps the release of SCL and the release of SDA. It checks the gap against `HOLD_TICKS`+1 periods of the clock enable.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int REG_W      = 16;
    localparam int B_START    = 0;
    localparam int B_STOP     = 1;
    localparam int B_FILT     = 4;
    localparam int B_TX_BUSY  = 8;
    localparam int B_RX_BUSY  = 9;
    localparam int N_CHAN     = 2;   // 0: transmit, 1: receive

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULL,
        SQ_RAISE,
        SQ_HOLD,
        SQ_RELEASE
    } sq_state_t;
endpackage

// File: rtl/i2cs_busy_flag.sv
module i2cs_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic begin_i,
    input  logic done_i,
    input  logic wait_i,
    output logic busy_o
);
    // wait forces idle, a new begin beats an end in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_o <= 1'b0;
        else if (wait_i)
            busy_o <= 1'b0;
        else if (begin_i)
            busy_o <= 1'b1;
        else if (done_i)
            busy_o <= 1'b0;
    end
endmodule

// File: rtl/i2cs_ctl_reg.sv
module i2cs_ctl_reg
    import i2cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             start_clr_i,
    input  logic             stop_clr_i,
    input  logic             seq_lock_i,
    output logic             start_o,
    output logic             stop_o,
    output logic             filt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_o  <= 1'b0;
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            if (wr_i)
                filt_o <= wdata_i[B_FILT];

            if (start_clr_i)
                start_o <= 1'b0;
            else if (wr_i)
                start_o <= wdata_i[B_START];

            // Clearing by the sequencer wins; while locked the bit stays set
            if (stop_clr_i)
                stop_o <= 1'b0;
            else if (wr_i && !seq_lock_i)
                stop_o <= wdata_i[B_STOP];
        end
    end
endmodule

// File: rtl/i2cs_stop_seq.sv
module i2cs_stop_seq
    import i2cs_pkg::*;
#(
    parameter int HOLD_TICKS = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch_i,
    input  logic      tick_i,
    output logic      sda_low_o,
    output logic      scl_low_o,
    output logic      finish_o,
    output logic      lock_o,
    output sq_state_t state_o
);
    localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);

    sq_state_t        state_q, state_d;
    logic [CNT_W-1:0] hold_q, hold_d;
    logic             hold_done;

    assign hold_done = (hold_q == CNT_W'(HOLD_TICKS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            SQ_IDLE: begin
                hold_d = '0;
                if (launch_i) state_d = SQ_PULL;
            end
            SQ_PULL:  if (tick_i) state_d = SQ_RAISE;
            SQ_RAISE: if (tick_i) state_d = SQ_HOLD;
            SQ_HOLD: begin
                if (tick_i) begin
                    if (hold_done) state_d = SQ_RELEASE;
                    else           hold_d  = hold_q + 1'b1;
                end
            end
            SQ_RELEASE: if (tick_i) state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sda_low_o = 1'b0;
        scl_low_o = 1'b0;
        finish_o  = 1'b0;
        lock_o    = 1'b0;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_PULL: begin
                sda_low_o = 1'b1;
                scl_low_o = 1'b1;
                lock_o    = 1'b1;
            end
            SQ_RAISE, SQ_HOLD: begin
                sda_low_o = 1'b1;
                lock_o    = 1'b1;
            end
            SQ_RELEASE: begin
                lock_o   = 1'b1;
                finish_o = tick_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/i2c_stop_ctl.sv
module i2c_stop_ctl
    import i2cs_pkg::*;
#(
    parameter int HOLD_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             scl_tick,
    input  logic             tx_begin,
    input  logic             rx_begin,
    input  logic             xfer_done,
    input  logic             wait_state,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             start_issued,
    output logic             start_req,
    output logic             filt_en,
    output logic             sda_drive_low,
    output logic             scl_drive_low,
    output logic             bus_free
);
    logic [N_CHAN-1:0] chan_begin;
    logic [N_CHAN-1:0] chan_busy;
    logic              stop_bit;
    logic              seq_finish;
    logic              seq_lock;
    logic              launch;
    logic              bus_free_q;
    sq_state_t         sq_state;

    assign chan_begin = {rx_begin, tx_begin};

    for (genvar g = 0; g < N_CHAN; g++) begin : g_busy
        i2cs_busy_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .begin_i (chan_begin[g]),
            .done_i  (xfer_done),
            .wait_i  (wait_state),
            .busy_o  (chan_busy[g])
        );
    end

    i2cs_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .wdata_i     (reg_wdata),
        .start_clr_i (start_issued),
        .stop_clr_i  (seq_finish),
        .seq_lock_i  (seq_lock),
        .start_o     (start_req),
        .stop_o      (stop_bit),
        .filt_o      (filt_en)
    );

    // A pending stop is only looked at when a transfer closes
    assign launch = xfer_done && stop_bit && !tx_en && !rx_en && !start_req
                    && (sq_state == SQ_IDLE);

    i2cs_stop_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .tick_i    (scl_tick),
        .sda_low_o (sda_drive_low),
        .scl_low_o (scl_drive_low),
        .finish_o  (seq_finish),
        .lock_o    (seq_lock),
        .state_o   (sq_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_free_q <= 1'b1;
        else if (seq_finish)
            bus_free_q <= 1'b1;
        else if (|chan_begin)
            bus_free_q <= 1'b0;
    end
    assign bus_free = bus_free_q;

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[B_START]   = start_req;
        reg_rdata[B_STOP]    = stop_bit;
        reg_rdata[B_FILT]    = filt_en;
        reg_rdata[B_TX_BUSY] = chan_busy[0];
        reg_rdata[B_RX_BUSY] = chan_busy[1];
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             xfer_done,
    input logic             wait_state,
    input logic             tx_en,
    input logic             rx_en,
    input logic             start_issued,
    input logic             sda_drive_low,
    input logic             scl_drive_low,
    input logic             bus_free,
    input sq_state_t        seq_state
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15:10] == 6'd0) && (reg_rdata[7:5] == 3'd0) && (reg_rdata[3:2] == 2'd0)); // R2

    AST_WAIT_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        wait_state |=> !reg_rdata[8]); // R4

    AST_WAIT_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        wait_state |=> !reg_rdata[9]); // R5

    AST_GATED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_IDLE && xfer_done && (tx_en || rx_en || reg_rdata[0]))
        |=> (!sda_drive_low && !scl_drive_low)); // R6

    AST_SDA_UP_WITH_SCL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low) |-> !scl_drive_low); // R7

    AST_FREE_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> (!reg_rdata[1] && !sda_drive_low && !scl_drive_low)); // R8

    AST_STOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == SQ_PULL || seq_state == SQ_RAISE || seq_state == SQ_HOLD)
         && reg_wr && !reg_wdata[1]) |=> reg_rdata[1]); // R9

    AST_START_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start_issued |=> !reg_rdata[0]); // R10
endmodule

bind i2c_stop_ctl i2cs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .xfer_done     (xfer_done),
    .wait_state    (wait_state),
    .tx_en         (tx_en),
    .rx_en         (rx_en),
    .start_issued  (start_issued),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .bus_free      (bus_free),
    .seq_state     (sq_state)
);

// File: tb/tb_i2c_stop_ctl.sv
`timescale 1ns/1ps
module tb_i2c_stop_ctl;
    localparam int HOLD  = 1;
    localparam int TDIV  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        scl_tick = 1'b0;
    logic        tx_begin = 1'b0, rx_begin = 1'b0, xfer_done = 1'b0;
    logic        wait_state = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic        start_issued = 1'b0;
    logic        start_req, filt_en, sda_drive_low, scl_drive_low, bus_free;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit ended = 0;
    int t_scl_up = 0;
    int t_sda_up = 0;

    logic [2:0] exp_q[$];     // {bus_free, sda_low, scl_low}
    logic [2:0] prev_obs;
    bit         mon_on = 0;

    always #10 clk = ~clk;    // 50 MHz

    i2c_stop_ctl #(.HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_tick(scl_tick), .tx_begin(tx_begin),
        .rx_begin(rx_begin), .xfer_done(xfer_done), .wait_state(wait_state),
        .tx_en(tx_en), .rx_en(rx_en), .start_issued(start_issued),
        .start_req(start_req), .filt_en(filt_en), .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low), .bus_free(bus_free)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] e);
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask
    task automatic pulse_tx();
        @(negedge clk); tx_begin = 1'b1;
        @(negedge clk); tx_begin = 1'b0;
    endtask
    task automatic pulse_rx();
        @(negedge clk); rx_begin = 1'b1;
        @(negedge clk); rx_begin = 1'b0;
    endtask
    task automatic pulse_wait();
        @(negedge clk); wait_state = 1'b1;
        @(negedge clk); wait_state = 1'b0;
    endtask
    task automatic pulse_start_issued();
        @(negedge clk); start_issued = 1'b1;
        @(negedge clk); start_issued = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // clock-enable generator
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            scl_tick = ((cyc % TDIV) == 0);
        end
    end

    // monitor: compare every change of the bus outputs against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            logic [2:0] obs;
            obs = {bus_free, sda_drive_low, scl_drive_low};
            if (obs !== prev_obs) begin
                if (prev_obs[0] && !obs[0]) t_scl_up = cyc;
                if (prev_obs[1] && !obs[1]) t_sda_up = cyc;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7 actual=%b expected=<no change>", obs);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    if (obs !== e) begin
                        bad++;
                        $display("FAIL R7 actual=%b expected=%b", obs, e);
                    end
                end
                prev_obs = obs;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 bus_free", bus_free, 1'b1);
        chk("R1 drives", {sda_drive_low, scl_drive_low, filt_en, start_req}, 4'b0000);
        prev_obs = {bus_free, sda_drive_low, scl_drive_low};
        mon_on = 1;

        // R2 reserved bits, busy flags read-only
        wr(16'hFFFF);
        chk("R2 all ones", reg_rdata, 16'h0013);
        wr(16'h0011);
        chk("R3 filt_en", filt_en, 1'b1);
        chk("R10 start_req", start_req, 1'b1);
        pulse_start_issued();
        chk("R10 start cleared", reg_rdata, 16'h0010);
        wr(16'h0000);
        chk("R3 filt_en off", filt_en, 1'b0);

        // R10 strobe wins over same-cycle write
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 16'h0001; start_issued = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; start_issued = 1'b0;
        chk("R10 clear beats write", reg_rdata[0], 1'b0);

        // R4 transmit busy
        push(3'b000);
        pulse_tx();
        chk("R4 tx busy set", reg_rdata, 16'h0100);
        chk("R8 bus_free falls", bus_free, 1'b0);
        wr(16'h0000);
        chk("R4 write ignored", reg_rdata, 16'h0100);
        pulse_done();
        chk("R4 tx busy cleared by done", reg_rdata, 16'h0000);
        pulse_tx();
        pulse_wait();
        chk("R4 tx busy cleared by wait", reg_rdata, 16'h0000);

        // R5 receive busy
        pulse_rx();
        chk("R5 rx busy set", reg_rdata, 16'h0200);
        pulse_wait();
        chk("R5 rx busy cleared by wait", reg_rdata, 16'h0000);
        pulse_rx();
        pulse_done();
        chk("R5 rx busy cleared by done", reg_rdata, 16'h0000);

        // R6 gating
        wr(16'h0002);
        tx_en = 1'b1;
        pulse_done();
        repeat (2 * TDIV) @(negedge clk);
        chk("R6 tx_en blocks", {reg_rdata[1], sda_drive_low, scl_drive_low}, 3'b100);
        tx_en = 1'b0; rx_en = 1'b1;
        pulse_done();
        repeat (2 * TDIV) @(negedge clk);
        chk("R6 rx_en blocks", {reg_rdata[1], sda_drive_low, scl_drive_low}, 3'b100);
        rx_en = 1'b0;
        wr(16'h0003);
        pulse_done();
        repeat (2 * TDIV) @(negedge clk);
        chk("R6 start blocks", {reg_rdata[1], sda_drive_low, scl_drive_low}, 3'b100);
        pulse_start_issued();
        repeat (2 * TDIV) @(negedge clk);
        chk("R6 no launch without done", {sda_drive_low, scl_drive_low}, 2'b00);

        // R7 sequence launch
        push(3'b011);
        push(3'b010);
        push(3'b000);
        push(3'b100);
        pulse_done();
        chk("R7 sequence started", {sda_drive_low, scl_drive_low}, 2'b11);
        wr(16'h0000);
        chk("R9 stop write ignored", reg_rdata[1], 1'b1);
        for (int i = 0; i < 200 && !bus_free; i++) @(negedge clk);
        chk("R8 stop bit self-clears", reg_rdata, 16'h0000);
        chk("R8 bus_free set", bus_free, 1'b1);
        repeat (2) @(negedge clk);
        chk("R7 all levels seen", exp_q.size(), 0);
        chk("R7 hold length", t_sda_up - t_scl_up, (HOLD + 1) * TDIV);

        // R8 bus_free falls on receive start
        push(3'b000);
        pulse_rx();
        chk("R8 bus_free falls rx", bus_free, 1'b0);
        pulse_done();
        repeat (2) @(negedge clk);
        chk("R7 queue drained", exp_q.size(), 0);

        finish_run();
    end
endmodule